// File: doc/BRIEF.md
# Chroma Macroblock Framer (4:2:2 in, 4:2:0 blocks out)

This block takes the chroma half of a raster 4:2:2 video stream, one pixel per clock and 8 bits per sample, and turns it into separate 8x8 Cb and Cr blocks ready for 4:2:0 coding. Each pixel carries one chroma sample, and the samples alternate: the even pixel of each horizontal pair holds Cb and the odd pixel holds Cr. Vertical decimation keeps only the even image lines. A band of 16 image rows therefore leaves 8 stored chroma lines.

Stored lines go into one of two line-buffer banks. The banks alternate between bands, so one bank fills while the other is read. When the last pixel of a band has been taken in, the readout engine works along the band one macroblock at a time, left to right. For each macroblock it shifts 16 buffered columns into an 8-row by 16-sample shift-register window. It then streams 64 Cb samples and 64 Cr samples, each set in raster order. Every sample leaves with a valid strobe, a start-of-block flag, a Cb/Cr flag and the macroblock coordinates.

Top module: `chroma_mb_framer`

## Requirements
- R1: While the active-low asynchronous reset `rstN` is low, and after it is released until the first band is complete, `outValid` and `outSob` are 0.
- R2: Each macroblock is emitted as 128 samples. The first 64 carry `outIsCr`=0 (Cb) and the last 64 carry `outIsCr`=1 (Cr). Each set of 64 is in raster order: row 0 columns 0..7, then row 1, and so on.
- R3: Within each pixel pair the even-x pixel carries Cb and the odd-x pixel carries Cr. Cb sample (row r, column k) of macroblock (mx, my) is the chroma of pixel x = 16*mx + 2k. The matching Cr sample comes from x = 16*mx + 2k + 1.
- R4: Row r of a block comes from image line 16*my + 2r. Samples on odd image lines have no effect on any output.
- R5: `outSob` is 1 on the first sample of the Cb block and on the first sample of the Cr block, and 0 on every other sample.
- R6: `outMbX` and `outMbY` give the macroblock column and row (pixel position divided by 16). They stay constant over the 128 samples of a macroblock.
- R7: A band's readout starts only after the last pixel of its 16th row is accepted. Macroblocks are emitted with `outMbX` ascending within a band, and bands follow from top to bottom.
- R8: A cycle with `pixValid`=0 is not a pixel. Its `pixChroma` value has no effect, and the raster position does not advance.
- R9: A valid pixel with `pixSof`=1 is taken as pixel (0,0) of a new frame, whatever the raster position was before.
- R10: `hRes` and `vRes` (multiples of 16, `hRes` up to MAX_WIDTH) set the line length and frame height. The raster wraps to the next line after `hRes` pixels and to line 0 after `vRes` lines. Each band yields `hRes`/16 macroblocks.
- R11: Bands alternate between two buffer banks. Pixels of the next band can arrive back to back while the previous band is being read out, and no data is lost.
- R12: The 128 samples of a macroblock appear on 128 consecutive cycles with `outValid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pixValid | input | 1 | Pixel present this cycle |
| pixSof | input | 1 | Pixel is the first of a frame |
| pixChroma | input | SAMPLE_W | Chroma sample (Cb on even x, Cr on odd x) |
| hRes | input | 16 | Line length in pixels, multiple of 16 |
| vRes | input | 16 | Frame height in lines, multiple of 16 |
| outValid | output | 1 | Output sample valid |
| outSob | output | 1 | First sample of an 8x8 block |
| outIsCr | output | 1 | 0 = Cb block, 1 = Cr block |
| outSample | output | SAMPLE_W | Block sample |
| outMbX | output | 12 | Macroblock column |
| outMbY | output | 12 | Macroblock row |

## Verification
The bench builds the block with SAMPLE_W=8 and MAX_WIDTH=64. The small buffer lets one frame fill every column of a line (64 pixels, four macroblocks per band) while the run stays short. Frames of 16x16, 48x32, 64x32 and 32x48 cover bands with one macroblock and with several, frames with an odd and an even number of bands (so bank alternation runs across frame boundaries), input gaps, and a partial line abandoned by a new start of frame. Every pixel value depends on both x and y, so a swapped Cb/Cr pair, an odd line leaking in or a shifted column changes the value the scoreboard sees.

// File: rtl/chroma_framer_pkg.sv
package chroma_framer_pkg;

  localparam int RES_W    = 16;          // resolution input width
  localparam int MB_W     = RES_W - 4;   // macroblock coordinate width
  localparam int WIN_ROWS = 8;           // stored chroma lines per band
  localparam int WIN_COLS = 16;          // interleaved samples per window row
  localparam int IDX_W    = 7;           // 2 blocks x 64 samples

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_LOAD = 2'd1,
    RD_EMIT = 2'd2
  } rd_state_t;

  typedef struct packed {
    logic             wrEn;
    logic             wrBank;
    logic [2:0]       wrRow;
    logic             shiftEn;
    logic             rdBank;
    logic             emitEn;
    logic [IDX_W-1:0] emitIdx;
  } framer_ctrl_t;

endpackage

// File: rtl/chroma_framer_ctrl.sv
module chroma_framer_ctrl
  import chroma_framer_pkg::*;
#(
  parameter int MAX_WIDTH = 64,
  localparam int COL_W = $clog2(MAX_WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic [RES_W-1:0] hRes,
  input  logic [RES_W-1:0] vRes,
  output framer_ctrl_t     ctrl,
  output logic [COL_W-1:0] wrCol,
  output logic [COL_W-1:0] rdCol,
  output logic [MB_W-1:0]  mbX,
  output logic [MB_W-1:0]  mbY
);

  // input raster tracking
  logic [RES_W-1:0] xCnt, yCnt;
  logic [RES_W-1:0] effX, effY;
  logic             fillBank;
  logic             lastCol, lastRow, bandDone;

  assign effX     = pixSof ? '0 : xCnt;
  assign effY     = pixSof ? '0 : yCnt;
  assign lastCol  = (effX == hRes - RES_W'(1));
  assign lastRow  = (effY == vRes - RES_W'(1));
  assign bandDone = pixValid && lastCol && (effY[3:0] == 4'hF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt     <= '0;
      yCnt     <= '0;
      fillBank <= 1'b0;
    end else if (pixValid) begin
      if (lastCol) begin
        xCnt <= '0;
        yCnt <= lastRow ? '0 : effY + RES_W'(1);
      end else begin
        xCnt <= effX + RES_W'(1);
        yCnt <= effY;
      end
      if (bandDone) fillBank <= ~fillBank;
    end
  end

  // readout sequencing
  rd_state_t        state;
  logic             rdBankQ;
  logic [MB_W-1:0]  mbXQ, mbYQ;
  logic [3:0]       colQ;
  logic [IDX_W-1:0] idxQ;
  logic             mbLast;

  assign mbLast = (mbXQ == hRes[RES_W-1:4] - MB_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RD_IDLE;
      rdBankQ <= 1'b0;
      mbXQ    <= '0;
      mbYQ    <= '0;
      colQ    <= '0;
      idxQ    <= '0;
    end else begin
      unique case (state)
        RD_IDLE: begin
          if (bandDone) begin
            state   <= RD_LOAD;
            rdBankQ <= fillBank;
            mbXQ    <= '0;
            mbYQ    <= effY[RES_W-1:4];
            colQ    <= '0;
          end
        end
        RD_LOAD: begin
          colQ <= colQ + 4'd1;
          if (colQ == 4'hF) begin
            state <= RD_EMIT;
            idxQ  <= '0;
          end
        end
        RD_EMIT: begin
          idxQ <= idxQ + IDX_W'(1);
          if (idxQ == {IDX_W{1'b1}}) begin
            if (mbLast) begin
              state <= RD_IDLE;
            end else begin
              state <= RD_LOAD;
              mbXQ  <= mbXQ + MB_W'(1);
              colQ  <= '0;
            end
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.wrEn    = pixValid && !effY[0];
    ctrl.wrBank  = fillBank;
    ctrl.wrRow   = effY[3:1];
    ctrl.shiftEn = (state == RD_LOAD);
    ctrl.rdBank  = rdBankQ;
    ctrl.emitEn  = (state == RD_EMIT);
    ctrl.emitIdx = idxQ;
  end

  assign wrCol = COL_W'(effX);
  assign rdCol = COL_W'({mbXQ, colQ});
  assign mbX   = mbXQ;
  assign mbY   = mbYQ;

endmodule

// File: rtl/chroma_framer_dp.sv
module chroma_framer_dp
  import chroma_framer_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_WIDTH = 64,
  localparam int COL_W = $clog2(MAX_WIDTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  framer_ctrl_t        ctrl,
  input  logic [COL_W-1:0]    wrCol,
  input  logic [COL_W-1:0]    rdCol,
  input  logic [MB_W-1:0]     mbX,
  input  logic [MB_W-1:0]     mbY,
  input  logic [SAMPLE_W-1:0] pixChroma,
  output logic                outValid,
  output logic                outSob,
  output logic                outIsCr,
  output logic [SAMPLE_W-1:0] outSample,
  output logic [MB_W-1:0]     outMbX,
  output logic [MB_W-1:0]     outMbY
);

  // two banks of decimated chroma lines
  logic [SAMPLE_W-1:0] lineMem [2][WIN_ROWS][MAX_WIDTH];

  always_ff @(posedge clk) begin
    if (ctrl.wrEn) lineMem[ctrl.wrBank][ctrl.wrRow][wrCol] <= pixChroma;
  end

  // 8 x 16 shift window, filled one column per shift
  logic [SAMPLE_W-1:0] win [WIN_ROWS][WIN_COLS];

  always_ff @(posedge clk) begin
    if (ctrl.shiftEn) begin
      for (int r = 0; r < WIN_ROWS; r++) begin
        for (int c = 0; c < WIN_COLS - 1; c++) win[r][c] <= win[r][c+1];
        win[r][WIN_COLS-1] <= lineMem[ctrl.rdBank][r][rdCol];
      end
    end
  end

  // de-interleave: index bit 6 picks Cr, bits 5:3 row, bits 2:0 column pair
  logic [2:0]          selRow;
  logic [3:0]          selCol;
  logic [SAMPLE_W-1:0] selSample;

  assign selRow    = ctrl.emitIdx[5:3];
  assign selCol    = {ctrl.emitIdx[2:0], ctrl.emitIdx[6]};
  assign selSample = win[selRow][selCol];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSob    <= 1'b0;
      outIsCr   <= 1'b0;
      outSample <= '0;
      outMbX    <= '0;
      outMbY    <= '0;
    end else begin
      outValid <= ctrl.emitEn;
      outSob   <= ctrl.emitEn && (ctrl.emitIdx[5:0] == 6'd0);
      if (ctrl.emitEn) begin
        outIsCr   <= ctrl.emitIdx[6];
        outSample <= selSample;
        outMbX    <= mbX;
        outMbY    <= mbY;
      end
    end
  end

endmodule

// File: rtl/chroma_mb_framer.sv
module chroma_mb_framer
  import chroma_framer_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_WIDTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixValid,
  input  logic                pixSof,
  input  logic [SAMPLE_W-1:0] pixChroma,
  input  logic [RES_W-1:0]    hRes,
  input  logic [RES_W-1:0]    vRes,
  output logic                outValid,
  output logic                outSob,
  output logic                outIsCr,
  output logic [SAMPLE_W-1:0] outSample,
  output logic [MB_W-1:0]     outMbX,
  output logic [MB_W-1:0]     outMbY
);

  localparam int COL_W = $clog2(MAX_WIDTH);

  framer_ctrl_t     ctrl;
  logic [COL_W-1:0] wrCol, rdCol;
  logic [MB_W-1:0]  mbX, mbY;

  chroma_framer_ctrl #(.MAX_WIDTH(MAX_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof),
    .hRes(hRes), .vRes(vRes), .ctrl(ctrl), .wrCol(wrCol), .rdCol(rdCol),
    .mbX(mbX), .mbY(mbY)
  );

  chroma_framer_dp #(.SAMPLE_W(SAMPLE_W), .MAX_WIDTH(MAX_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrCol(wrCol), .rdCol(rdCol),
    .mbX(mbX), .mbY(mbY), .pixChroma(pixChroma),
    .outValid(outValid), .outSob(outSob), .outIsCr(outIsCr),
    .outSample(outSample), .outMbX(outMbX), .outMbY(outMbY)
  );

endmodule

// File: rtl/chroma_mb_framer_checks.sv
module chroma_mb_framer_checks
  import chroma_framer_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            outValid,
  input logic            outSob,
  input logic            outIsCr,
  input logic [MB_W-1:0] outMbX,
  input logic [MB_W-1:0] outMbY
);

  // position within the current 128-sample macroblock
  logic [6:0] seenCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenCnt <= '0;
    else if (outValid) seenCnt <= seenCnt + 7'd1;
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R1: assert (!outValid && !outSob);
  end

  assert_cb_then_cr_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outIsCr == seenCnt[6]));

  assert_sob_position_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSob == (seenCnt[5:0] == 6'd0)));

  assert_sob_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    outSob |-> outValid);

  assert_coord_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenCnt != 7'd127) |=> ($stable(outMbX) && $stable(outMbY)));

  assert_burst_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenCnt != 7'd127) |=> outValid);

endmodule

bind chroma_mb_framer chroma_mb_framer_checks u_checks (.*);

// File: tb/chroma_mb_framer_bench.sv
module chroma_mb_framer_bench;

  localparam int SW = 8;
  localparam int MW = 64;

  typedef struct packed {
    logic [SW-1:0] s;
    logic          cr;
    logic          sob;
    logic [11:0]   mx;
    logic [11:0]   my;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pixValid = 1'b0;
  logic          pixSof = 1'b0;
  logic [SW-1:0] pixChroma = '0;
  logic [15:0]   hRes = 16'd16;
  logic [15:0]   vRes = 16'd16;
  logic          outValid, outSob, outIsCr;
  logic [SW-1:0] outSample;
  logic [11:0]   outMbX, outMbY;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  exp_t q[$];
  int   runLen = 0;

  always #5 clk = ~clk;

  chroma_mb_framer #(.SAMPLE_W(SW), .MAX_WIDTH(MW)) u_chroma_mb_framer (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof),
    .pixChroma(pixChroma), .hRes(hRes), .vRes(vRes),
    .outValid(outValid), .outSob(outSob), .outIsCr(outIsCr),
    .outSample(outSample), .outMbX(outMbX), .outMbY(outMbY)
  );

  function automatic logic [SW-1:0] pv(int f, int x, int y);
    return SW'(x * 5 + y * 17 + f * 41 + (x >> 3));
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expected blocks for one frame: R2 R3 R4 R5 R6 R7 R10
  task automatic pushFrame(int f, int w, int h);
    for (int my = 0; my < h / 16; my++)
      for (int mx = 0; mx < w / 16; mx++)
        for (int cr = 0; cr < 2; cr++)
          for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++) begin
              exp_t e;
              e.s   = pv(f, mx * 16 + 2 * k + cr, my * 16 + 2 * r);
              e.cr  = cr[0];
              e.sob = (r == 0 && k == 0);
              e.mx  = 12'(mx);
              e.my  = 12'(my);
              q.push_back(e);
            end
  endtask

  // drive one frame; gapMod > 0 inserts idle cycles with junk data (R8)
  task automatic driveFrame(int f, int w, int h, int gapMod);
    @(negedge clk);
    hRes = 16'(w);
    vRes = 16'(h);
    pushFrame(f, w, h);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        if (gapMod > 0 && ((x + y) % gapMod) == 0) begin
          pixValid  = 1'b0;
          pixSof    = 1'b1;
          pixChroma = 8'hEE;
          @(negedge clk);
        end
        pixValid  = 1'b1;
        pixSof    = (x == 0 && y == 0);
        pixChroma = pv(f, x, y);
        @(negedge clk);
      end
    pixValid  = 1'b0;
    pixSof    = 1'b0;
    pixChroma = 8'h5A;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        runLen++;
        if (q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R7 R9: unexpected output sample actual=%0h expected=none", outSample);
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (outSample !== e.s) begin
            errors++;
            $display("FAIL R3 R4: sample mb(%0d,%0d) cr=%0d actual=%0h expected=%0h",
                     e.mx, e.my, e.cr, outSample, e.s);
          end else if (outIsCr !== e.cr || outSob !== e.sob) begin
            errors++;
            $display("FAIL R2 R5: flags actual cr=%0b sob=%0b expected cr=%0b sob=%0b",
                     outIsCr, outSob, e.cr, e.sob);
          end else if (outMbX !== e.mx || outMbY !== e.my) begin
            errors++;
            $display("FAIL R6 R7: coords actual=(%0d,%0d) expected=(%0d,%0d)",
                     outMbX, outMbY, e.mx, e.my);
          end
        end
      end else if (runLen != 0) begin
        checks++;
        if (runLen % 128 != 0) begin
          errors++;
          $display("FAIL R12: burst broken actual=%0d samples expected=multiple of 128", runLen);
        end
        runLen = 0;
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 60000; i++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    idle(4);
    checks++;
    if (outValid !== 1'b0 || outSob !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset actual valid=%0b sob=%0b expected 0 0", outValid, outSob);
    end
    rstN = 1'b1;
    idle(3);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset actual valid=%0b expected 0", outValid);
    end

    // single macroblock frame, one band (R10)
    driveFrame(0, 16, 16, 0);
    idle(700);
    // several macroblocks per band, with gaps (R8, R10)
    driveFrame(1, 48, 32, 5);
    idle(700);
    // full buffer width, back-to-back bands across banks (R11)
    driveFrame(2, 64, 32, 0);
    idle(700);
    // abandoned partial line then a new start of frame (R9)
    @(negedge clk);
    hRes = 16'd32;
    vRes = 16'd48;
    for (int i = 0; i < 20; i++) begin
      pixValid  = 1'b1;
      pixSof    = 1'b0;
      pixChroma = 8'hC3 ^ 8'(i);
      @(negedge clk);
    end
    pixValid = 1'b0;
    driveFrame(3, 32, 48, 3);
    idle(900);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 R7: missing outputs actual=%0d left expected=0", q.size());
    end
    finishRun();
  end

endmodule